// File: doc/BRIEF.md
# Data address watchpoint matcher

This block is a debug watchpoint for a 64-bit load/store unit. Software or a debug agent programs two registers through a plain write port: a watch address that sets the base of the window, and a watch control word that sets the window length, which access kinds are watched and which privilege levels are watched. In every cycle the block compares the data access being presented with the programmed window and raises a hit flag. The flag arrives one cycle after the access is presented, so a later stage can still suppress the access before it commits.

The window always starts on an 8-byte boundary and covers between 8 and 512 bytes. Any access whose bytes overlap the window counts as a hit, including an unaligned access that straddles either edge. A hit also requires the access kind and the current privilege level to be enabled. Registers use MSB-first bit numbering: field bit k of a 64-bit register is wire bit 63-k.

Top module: `data_watch_unit`

## Requirements
- R1: After synchronous reset `hit` is 0 and both registers are zero, so no access hits until the registers are written.
- R2: A write with `reg_we`=1 and `reg_sel`=0 loads the watch base from `reg_wdata`; wire bits 2:0 (MSB-first bits 61..63) are discarded, so the base is always 8-byte aligned.
- R3: The range field is wire bits 15:10 of the control word (MSB-first bits 48..53); the window length is (field+1)*8 bytes, from 8 to 512.
- R4: A hit needs the access bytes [addr, addr+2^size) to overlap [base, base+length), with both sums taken without wraparound (65-bit); straddling accesses hit, and an access that ends exactly at base or starts exactly at base+length does not.
- R5: Control wire bit 6 (MSB-first 57) enables hits on writes (`acc_wr`=1) and wire bit 5 (MSB-first 58) enables hits on reads; with both clear nothing hits.
- R6: Control wire bits 2, 1, 0 (MSB-first 61, 62, 63) enable hits at hypervisor (`acc_priv`=2), supervisor (`acc_priv`=1) and problem (`acc_priv`=0) state; `acc_priv`=3 never hits, and with all three bits clear nothing hits.
- R7: Control wire bit 7 (MSB-first 56) and every other control bit outside the fields above have no effect on matching.
- R8: The hit for an access presented at a rising edge appears on `hit` right after that edge and lasts one cycle, ahead of the access committing.
- R9: A register write takes effect for accesses presented from the next edge on; an access presented at the same edge as the write is judged against the old value.
- R10: When `acc_valid` is 0 the following cycle shows `hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the watch base, 1 the control word |
| reg_wdata | input | 64 | Register write data |
| acc_valid | input | 1 | A data access is presented this cycle |
| acc_addr | input | 64 | Byte address of the access |
| acc_size | input | 2 | Access size as log2 of bytes (0..3 for 1..8 bytes) |
| acc_wr | input | 1 | 1 for a store, 0 for a load |
| acc_priv | input | 2 | 0 problem, 1 supervisor, 2 hypervisor, 3 none |
| hit | output | 1 | Registered watchpoint hit for the previous cycle's access |

## Verification
Every result of this block is due exactly one edge after its stimulus: the hit flag for an access, and the new register contents for a write, which show up as changed hit behaviour for the access presented at the following edge. The bench drives each cycle's inputs at the falling edge, computes the expected hit from its own copy of the registers before applying that cycle's write, and samples `hit` two nanoseconds after the next rising edge. Presenting an access in the same cycle as a write therefore checks that the old settings still apply, and the access in the next cycle checks the new ones.

// File: rtl/dwu_pkg.sv
package dwu_pkg;

  localparam int REG_W     = 64;
  localparam int RANGE_W   = 6;
  localparam int NUM_PRIV  = 3;
  localparam int ALIGN_LG  = 3;

  // Wire positions for MSB-first field bit k: REG_W-1-k
  localparam int RANGE_LO  = REG_W - 1 - 53;  // 10
  localparam int WR_BIT    = REG_W - 1 - 57;  // 6
  localparam int RD_BIT    = REG_W - 1 - 58;  // 5
  localparam int HYP_BIT   = REG_W - 1 - 61;  // 2
  localparam int SUP_BIT   = REG_W - 1 - 62;  // 1
  localparam int PROB_BIT  = REG_W - 1 - 63;  // 0

  typedef enum logic [1:0] {
    PRIV_PROB = 2'd0,
    PRIV_SUP  = 2'd1,
    PRIV_HYP  = 2'd2,
    PRIV_NONE = 2'd3
  } priv_e;

  typedef struct packed {
    logic [RANGE_W-1:0]  mrange;
    logic                rd_en;
    logic                wr_en;
    logic [NUM_PRIV-1:0] priv_en;  // index = privilege code
  } wctl_t;

endpackage

// File: rtl/dwu_regs.sv
module dwu_regs
  import dwu_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] base,
  output wctl_t         ctl
);

  logic [DW-1:ALIGN_LG] base_q;
  wctl_t                ctl_q;
  wctl_t                ctl_d;

  always_comb begin
    ctl_d.mrange  = wdata[RANGE_LO +: RANGE_W];
    ctl_d.rd_en   = wdata[RD_BIT];
    ctl_d.wr_en   = wdata[WR_BIT];
    ctl_d.priv_en = {wdata[HYP_BIT], wdata[SUP_BIT], wdata[PROB_BIT]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      ctl_q  <= '0;
    end else if (we) begin
      if (sel) ctl_q  <= ctl_d;
      else     base_q <= wdata[DW-1:ALIGN_LG];
    end
  end

  assign base = {base_q, {ALIGN_LG{1'b0}}};
  assign ctl  = ctl_q;

endmodule

// File: rtl/dwu_range.sv
module dwu_range
  import dwu_pkg::*;
#(
  parameter int AW     = REG_W,
  parameter int SIZE_W = 2
) (
  input  logic [AW-1:0]      base,
  input  logic [RANGE_W-1:0] mrange,
  input  logic [AW-1:0]      acc_addr,
  input  logic [SIZE_W-1:0]  acc_size,
  output logic               overlap
);

  localparam int EW = AW + 1;

  logic [EW-1:0] acc_lo, acc_hi, win_lo, win_hi, win_len;

  always_comb begin
    acc_lo  = {1'b0, acc_addr};
    acc_hi  = acc_lo + (EW'(1) << acc_size);
    win_lo  = {1'b0, base};
    win_len = (EW'(mrange) + EW'(1)) << ALIGN_LG;
    win_hi  = win_lo + win_len;
    overlap = (acc_lo < win_hi) && (win_lo < acc_hi);
  end

endmodule

// File: rtl/dwu_qual.sv
module dwu_qual
  import dwu_pkg::*;
(
  input  wctl_t       ctl,
  input  logic        acc_wr,
  input  logic [1:0]  acc_priv,
  output logic        allowed
);

  logic [NUM_PRIV-1:0] lvl_ok;

  for (genvar g = 0; g < NUM_PRIV; g++) begin : g_lvl
    assign lvl_ok[g] = ctl.priv_en[g] && (acc_priv == 2'(g));
  end

  logic kind_ok;
  assign kind_ok = acc_wr ? ctl.wr_en : ctl.rd_en;
  assign allowed = kind_ok && (|lvl_ok);

endmodule

// File: rtl/data_watch_unit.sv
module data_watch_unit
  import dwu_pkg::*;
#(
  parameter int AW     = REG_W,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [AW-1:0]     reg_wdata,
  input  logic              acc_valid,
  input  logic [AW-1:0]     acc_addr,
  input  logic [SIZE_W-1:0] acc_size,
  input  logic              acc_wr,
  input  logic [1:0]        acc_priv,
  output logic              hit
);

  logic [AW-1:0] base_q;
  wctl_t         ctl_q;
  logic          in_window;
  logic          allowed;
  logic          hit_q;

  dwu_regs #(.DW(AW)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .base  (base_q),
    .ctl   (ctl_q)
  );

  dwu_range #(.AW(AW), .SIZE_W(SIZE_W)) u_range (
    .base     (base_q),
    .mrange   (ctl_q.mrange),
    .acc_addr (acc_addr),
    .acc_size (acc_size),
    .overlap  (in_window)
  );

  dwu_qual u_qual (
    .ctl      (ctl_q),
    .acc_wr   (acc_wr),
    .acc_priv (acc_priv),
    .allowed  (allowed)
  );

  always_ff @(posedge clk) begin
    if (rst) hit_q <= 1'b0;
    else     hit_q <= acc_valid && in_window && allowed;
  end

  assign hit = hit_q;

endmodule

// File: rtl/dwu_checker.sv
module dwu_checker
  import dwu_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        reg_we,
  input logic        reg_sel,
  input logic [63:0] reg_wdata,
  input logic        acc_valid,
  input logic        acc_wr,
  input logic [1:0]  acc_priv,
  input wctl_t       ctl_q,
  input logic        hit
);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !hit);

  p_wr_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_wr && !ctl_q.wr_en) |=> !hit);

  p_rd_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_wr && !ctl_q.rd_en) |=> !hit);

  p_priv_gate_r6: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && (acc_priv == 2'd3 || ctl_q.priv_en == '0)) |=> !hit);

  p_ctl_load_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_we && reg_sel) |=> (ctl_q.mrange == $past(reg_wdata[15:10]) &&
                             ctl_q.wr_en == $past(reg_wdata[6]) &&
                             ctl_q.rd_en == $past(reg_wdata[5]) &&
                             ctl_q.priv_en == $past(reg_wdata[2:0])));

  p_ctl_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_sel) |=> $stable(ctl_q));

endmodule

bind data_watch_unit dwu_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_sel   (reg_sel),
  .reg_wdata (reg_wdata),
  .acc_valid (acc_valid),
  .acc_wr    (acc_wr),
  .acc_priv  (acc_priv),
  .ctl_q     (ctl_q),
  .hit       (hit)
);

// File: tb/data_watch_unit_test.sv
`timescale 1ns/1ps
module data_watch_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0, reg_sel = 1'b0;
  logic [63:0] reg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [63:0] acc_addr = '0;
  logic [1:0]  acc_size = '0;
  logic        acc_wr = 1'b0;
  logic [1:0]  acc_priv = '0;
  logic        hit;

  int checks = 0;
  int failures = 0;

  // bench copy of the programmed state
  logic [63:0] m_base = '0;
  logic [5:0]  m_rng = '0;
  logic        m_rd = 1'b0, m_wr = 1'b0;
  logic [2:0]  m_pen = '0;

  always #5 clk = ~clk;

  data_watch_unit uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wr(acc_wr), .acc_priv(acc_priv), .hit(hit)
  );

  function automatic logic [63:0] mkctl(input logic [5:0] rng, input logic rd,
                                        input logic wr, input logic [2:0] pen,
                                        input logic alt, input logic [63:0] junk);
    logic [63:0] v;
    v = junk;
    v[15:10] = rng;
    v[6] = wr;
    v[5] = rd;
    v[7] = alt;
    v[2:0] = pen;
    return v;
  endfunction

  function automatic logic exp_hit(input logic v, input logic [63:0] a,
                                   input logic [1:0] sz, input logic w,
                                   input logic [1:0] p);
    logic [64:0] alo, ahi, wlo, whi;
    logic kind, lvl;
    alo  = {1'b0, a};
    ahi  = alo + (65'd1 << sz);
    wlo  = {1'b0, m_base};
    whi  = wlo + ((65'(m_rng) + 65'd1) * 65'd8);
    kind = w ? m_wr : m_rd;
    lvl  = (p != 2'd3) && m_pen[p];
    return v && (alo < whi) && (wlo < ahi) && kind && lvl;
  endfunction

  task automatic cyc(input logic we, input logic sel, input logic [63:0] wd,
                     input logic v, input logic [63:0] a, input logic [1:0] sz,
                     input logic w, input logic [1:0] p, input string tag);
    logic e;
    @(negedge clk);
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    acc_valid = v; acc_addr = a; acc_size = sz; acc_wr = w; acc_priv = p;
    e = exp_hit(v, a, sz, w, p);
    @(posedge clk);
    #2;
    checks++;
    if (hit !== e) begin
      failures++;
      $display("FAIL %s addr=%h size=%0d wr=%0b priv=%0d hit=%0b expected=%0b",
               tag, a, sz, w, p, hit, e);
    end
    if (we) begin
      if (sel) begin
        m_rng = wd[15:10]; m_wr = wd[6]; m_rd = wd[5]; m_pen = wd[2:0];
      end else begin
        m_base = {wd[63:3], 3'b000};
      end
    end
  endtask

  task automatic acc(input logic [63:0] a, input logic [1:0] sz, input logic w,
                     input logic [1:0] p, input string tag);
    cyc(1'b0, 1'b0, 64'd0, 1'b1, a, sz, w, p, tag);
  endtask

  task automatic wr_base(input logic [63:0] v);
    cyc(1'b1, 1'b0, v, 1'b0, 64'd0, 2'd0, 1'b0, 2'd0, "R2 base write");
  endtask

  task automatic wr_ctl(input logic [63:0] v);
    cyc(1'b1, 1'b1, v, 1'b0, 64'd0, 2'd0, 1'b0, 2'd0, "R7 ctl write");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired checks=%0d expected=done", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    checks++;
    if (hit !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset hit=%0b expected=0", hit);
    end
    // R1: zero registers, nothing hits even at address 0
    acc(64'd0, 2'd3, 1'b1, 2'd2, "R1 reset state");
    acc(64'd0, 2'd0, 1'b0, 2'd0, "R1 reset state");

    // R2: low address bits dropped
    wr_base(64'h0000_0000_0000_1007);
    wr_ctl(mkctl(6'd0, 1'b1, 1'b1, 3'b111, 1'b0, 64'd0));
    acc(64'h1000, 2'd0, 1'b0, 2'd0, "R2 aligned base");
    acc(64'h0FFF, 2'd0, 1'b0, 2'd0, "R2 below base");
    acc(64'h1007, 2'd0, 1'b1, 2'd1, "R3 last byte len8");
    acc(64'h1008, 2'd0, 1'b1, 2'd1, "R3 past len8");

    // R3/R4: max range and edge straddles
    wr_base(64'h0000_0000_0001_0000);
    wr_ctl(mkctl(6'd63, 1'b1, 1'b1, 3'b111, 1'b0, 64'd0));
    acc(64'h0FFFE, 2'd2, 1'b0, 2'd2, "R4 straddle low edge");
    acc(64'h0FFFC, 2'd2, 1'b0, 2'd2, "R4 ends at base");
    acc(64'h101FF, 2'd3, 1'b1, 2'd2, "R3 straddle high edge len512");
    acc(64'h10200, 2'd3, 1'b1, 2'd2, "R3 starts at end len512");

    // R5: kind enables
    wr_ctl(mkctl(6'd3, 1'b1, 1'b0, 3'b111, 1'b0, 64'd0));
    acc(64'h10008, 2'd1, 1'b0, 2'd0, "R5 read enabled");
    acc(64'h10008, 2'd1, 1'b1, 2'd0, "R5 write disabled");
    wr_ctl(mkctl(6'd3, 1'b0, 1'b1, 3'b111, 1'b0, 64'd0));
    acc(64'h10008, 2'd1, 1'b0, 2'd0, "R5 read disabled");
    acc(64'h10008, 2'd1, 1'b1, 2'd0, "R5 write enabled");
    wr_ctl(mkctl(6'd3, 1'b0, 1'b0, 3'b111, 1'b0, 64'd0));
    acc(64'h10008, 2'd1, 1'b1, 2'd0, "R5 both kinds off");

    // R6: privilege enables
    for (int pl = 0; pl < 3; pl++) begin
      wr_ctl(mkctl(6'd3, 1'b1, 1'b1, 3'(1 << pl), 1'b0, 64'd0));
      for (int pa = 0; pa < 4; pa++)
        acc(64'h10000, 2'd3, 1'b1, 2'(pa), "R6 privilege level");
    end
    wr_ctl(mkctl(6'd3, 1'b1, 1'b1, 3'b000, 1'b0, 64'd0));
    acc(64'h10000, 2'd3, 1'b1, 2'd2, "R6 all levels off");

    // R7: alternate mode bit and junk bits ignored
    wr_ctl(mkctl(6'd3, 1'b1, 1'b1, 3'b111, 1'b1, 64'hA5A5_5A5A_F0F0_0318));
    acc(64'h1001F, 2'd0, 1'b0, 2'd1, "R7 alt bit set, inside");
    acc(64'h10020, 2'd0, 1'b0, 2'd1, "R7 alt bit set, outside");

    // R9: write and access in the same cycle use old settings
    cyc(1'b1, 1'b1, mkctl(6'd3, 1'b0, 1'b0, 3'b000, 1'b0, 64'd0),
        1'b1, 64'h10000, 2'd0, 1'b0, 2'd0, "R9 same-cycle old ctl");
    acc(64'h10000, 2'd0, 1'b0, 2'd0, "R9 next-cycle new ctl");
    wr_ctl(mkctl(6'd0, 1'b1, 1'b1, 3'b111, 1'b0, 64'd0));
    cyc(1'b1, 1'b0, 64'h2_0000, 1'b1, 64'h10000, 2'd0, 1'b0, 2'd0,
        "R9 same-cycle old base");
    acc(64'h10000, 2'd0, 1'b0, 2'd0, "R9 next-cycle new base");
    acc(64'h20000, 2'd0, 1'b0, 2'd0, "R9 new base hits");

    // R4: window at the top of the address space does not wrap
    wr_base(64'hFFFF_FFFF_FFFF_FFF8);
    wr_ctl(mkctl(6'd63, 1'b1, 1'b1, 3'b111, 1'b0, 64'd0));
    acc(64'hFFFF_FFFF_FFFF_FFFF, 2'd0, 1'b1, 2'd0, "R4 top byte");
    acc(64'h0, 2'd3, 1'b1, 2'd0, "R4 no wrap to zero");

    // R10 / R8: valid low never hits; back-to-back hits are one cycle each
    cyc(1'b0, 1'b0, 64'd0, 1'b0, 64'hFFFF_FFFF_FFFF_FFF8, 2'd3, 1'b1, 2'd0,
        "R10 valid low");
    acc(64'hFFFF_FFFF_FFFF_FFF8, 2'd3, 1'b1, 2'd0, "R8 hit one cycle later");
    cyc(1'b0, 1'b0, 64'd0, 1'b0, 64'd0, 2'd0, 1'b0, 2'd0, "R8 hit drops");

    // random traffic near the window
    wr_base(64'h0000_1234_5678_9A00);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 32);
      if (r == 0) begin
        wr_ctl(mkctl(6'($urandom), 1'($urandom), 1'($urandom), 3'($urandom),
                     1'($urandom), {$urandom, $urandom}));
      end else if (r == 1) begin
        wr_base({$urandom, $urandom});
      end else begin
        logic [63:0] a;
        a = m_base + 64'($urandom % 560) - 64'd24;
        cyc(1'b0, 1'b0, 64'd0, ($urandom % 8) != 0, a, 2'($urandom),
            1'($urandom), 2'($urandom), "R4 random overlap");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule